// File: doc/BRIEF.md
# PWM Generator with AXI4-Lite Register Port

This block is a pulse-width modulator that software controls through a small AXI4-Lite slave. A free-running counter steps once per bus clock while an external enable pin is high. The output pin is high while the counter is below the active duty value. The duty register is one bit wider than the counter, so the duty range covers both fully off and fully on. Software writes the duty over the bus and can read back both the stored duty and the live counter.

A duty value written over the bus is held in a staging register. It moves into the comparator only when the counter wraps, so every period uses a single duty value. Each wrap raises a one-clock interrupt pulse. The PWM output and the interrupt leave the block as plain pins. The block runs on the bus clock and uses the bus active-low reset, applied synchronously.

Top module: `pwm_axil_top`

## Requirements
- R1: While `aresetn` is low and after it is released, the stored duty is 0, the counter is 0, `irq` is 0 and `pwm_out` is 0. A read at 0x00 and a read at 0x04 both return 0.
- R2: On each clock with `pwm_en` high, the counter advances by one and wraps from 255 to 0. A read at offset 0x04 returns the counter value, zero-extended, as it stood at the clock edge that accepted the read address.
- R3: `irq` is high for exactly one clock per wrap. That clock is the first one in which the counter shows 0 after the wrap, so there is one pulse in every 256 enabled clocks.
- R4: `pwm_out` is high exactly when the counter is below the active duty. An active duty of 0 gives 0 high clocks per period. A duty from 1 to 255 gives that many high clocks. A duty of 256 to 511 gives 256 high clocks, so the output stays high.
- R5: A written duty value reaches the comparator only at the next wrap. Until then, the rest of the current period follows the earlier value.
- R6: While `pwm_en` is low, the counter and `pwm_out` hold their values and no `irq` pulse occurs, even when the counter is frozen at 255.
- R7: A write completes whether address and data arrive together, address first or data first. Each write returns one `bvalid` pulse with `bresp` = 2'b00 (OKAY), and `bvalid` stays high until `bready` is high.
- R8: A write to offset 0x00 stores data bits 7:0 when `wstrb[0]` is set and data bit 8 when `wstrb[1]` is set. Data bits 31:9 and strobe bits 3:2 are ignored.
- R9: A read at offset 0x00 returns the stored duty zero-extended to 32 bits, even before that value has become active. `rvalid` stays high until `rready` is high, and `rresp` is 2'b00.
- R10: A read at any offset other than 0x00 and 0x04 returns 0 with OKAY. A write to any offset other than 0x00, including 0x04, changes neither the duty nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus clock |
| aresetn | input | 1 | Active-low synchronous reset |
| awaddr | input | 4 | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| araddr | input | 4 | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted |
| pwm_en | input | 1 | External count enable |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | One-clock pulse on each counter wrap |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a period: the old value must still govern the rest of that period. The stimulus waits until a bench-side counter model reaches a chosen value, writes a new duty, and then samples `pwm_out` further into the same period and again in the next one. A related case is an enable drop while the counter sits at 255. The stimulus stops at exactly that count, so any pulse that slips past the freeze is caught by counting `irq` during the frozen interval. A duty sweep covers the edge values around 0, 255 and 256, and counts high clocks over one full period.

// File: rtl/pwm_axil_pkg.sv
package pwm_axil_pkg;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01,
      RESP_SLVERR = 2'b10,
      RESP_DECERR = 2'b11
   } axi_resp_e;

   // Word index of each register (byte offset / 4)
   localparam int unsigned IDX_DUTY  = 0;
   localparam int unsigned IDX_COUNT = 1;

   function automatic int lanes_for(input int bits);
      return (bits + 7) / 8;
   endfunction

endpackage

// File: rtl/pwm_axil_wr.sv
module pwm_axil_wr
   import pwm_axil_pkg::*;
#(
   parameter  int ADDR_W = 4,
   parameter  int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_go,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);

   logic              aw_got_q, w_got_q, bvalid_q;
   logic [ADDR_W-1:0] aw_addr_q;
   logic [DATA_W-1:0] w_data_q;
   logic [STRB_W-1:0] w_strb_q;
   logic              aw_fire, w_fire, have_aw, have_w;

   assign awready = !aw_got_q && !bvalid_q;
   assign wready  = !w_got_q && !bvalid_q;
   assign aw_fire = awvalid && awready;
   assign w_fire  = wvalid && wready;
   assign have_aw = aw_got_q || aw_fire;
   assign have_w  = w_got_q || w_fire;
   assign wr_go   = have_aw && have_w;

   assign wr_addr = aw_got_q ? aw_addr_q : awaddr;
   assign wr_data = w_got_q ? w_data_q : wdata;
   assign wr_strb = w_got_q ? w_strb_q : wstrb;

   assign bvalid = bvalid_q;
   assign bresp  = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rstn) begin
         aw_got_q  <= 1'b0;
         w_got_q   <= 1'b0;
         bvalid_q  <= 1'b0;
         aw_addr_q <= '0;
         w_data_q  <= '0;
         w_strb_q  <= '0;
      end else begin
         if (bvalid_q && bready) bvalid_q <= 1'b0;
         if (wr_go) begin
            aw_got_q <= 1'b0;
            w_got_q  <= 1'b0;
            bvalid_q <= 1'b1;
         end else begin
            if (aw_fire) begin
               aw_got_q  <= 1'b1;
               aw_addr_q <= awaddr;
            end
            if (w_fire) begin
               w_got_q  <= 1'b1;
               w_data_q <= wdata;
               w_strb_q <= wstrb;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_axil_rd.sv
module pwm_axil_rd
   import pwm_axil_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_word
);

   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic              ar_fire;

   assign arready = !rvalid_q;
   assign ar_fire = arvalid && arready;
   assign rd_addr = araddr;
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rstn) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (rvalid_q && rready) rvalid_q <= 1'b0;
         if (ar_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
         end
      end
   end

endmodule

// File: rtl/pwm_axil_regs.sv
module pwm_axil_regs
   import pwm_axil_pkg::*;
#(
   parameter  int ADDR_W = 4,
   parameter  int DATA_W = 32,
   parameter  int CNT_W  = 8,
   localparam int DUTY_W = CNT_W + 1,
   localparam int STRB_W = DATA_W / 8,
   localparam int IDX_W  = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DUTY_W-1:0] duty,
   output logic [DATA_W-1:0] rd_word
);

   logic [DUTY_W-1:0] duty_q, duty_d;
   logic              sel_duty;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic              unused_bits;

   assign wr_idx   = wr_addr[ADDR_W-1:2];
   assign rd_idx   = rd_addr[ADDR_W-1:2];
   assign sel_duty = wr_go && (wr_idx == IDX_W'(IDX_DUTY));

   // Per-bit merge under the byte strobe that covers each bit
   always_comb begin
      for (int i = 0; i < DUTY_W; i++) begin
         duty_d[i] = (sel_duty && wr_strb[i / 8]) ? wr_data[i] : duty_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rstn) duty_q <= '0;
      else       duty_q <= duty_d;
   end

   assign duty = duty_q;

   always_comb begin
      rd_word = '0;
      if (rd_idx == IDX_W'(IDX_DUTY))       rd_word[DUTY_W-1:0] = duty_q;
      else if (rd_idx == IDX_W'(IDX_COUNT)) rd_word[CNT_W-1:0]  = cnt;
   end

   assign unused_bits = ^{wr_data, wr_addr[1:0], rd_addr[1:0], wr_strb};

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
   parameter  int CNT_W   = 8,
   parameter  bit REG_OUT = 1'b0,
   localparam int DUTY_W  = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rstn,
   input  logic              en,
   input  logic [DUTY_W-1:0] duty_staged,
   output logic [CNT_W-1:0]  cnt,
   output logic [DUTY_W-1:0] duty_act,
   output logic              wrap_pulse,
   output logic              pwm
);

   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0]  cnt_q;
   logic [DUTY_W-1:0] act_q;
   logic              pulse_q;
   logic              wrap;
   logic              below;

   assign wrap = en && (cnt_q == CNT_TOP);

   always_ff @(posedge clk) begin
      if (!rstn) begin
         cnt_q   <= '0;
         act_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= wrap;
         if (en) cnt_q <= cnt_q + 1'b1;
         if (wrap) act_q <= duty_staged;
      end
   end

   assign below = ({1'b0, cnt_q} < act_q);

   generate
      if (REG_OUT) begin : g_reg_out
         logic pwm_q;
         always_ff @(posedge clk) begin
            if (!rstn) pwm_q <= 1'b0;
            else       pwm_q <= below;
         end
         assign pwm = pwm_q;
      end else begin : g_comb_out
         assign pwm = below;
      end
   endgenerate

   assign cnt        = cnt_q;
   assign duty_act   = act_q;
   assign wrap_pulse = pulse_q;

endmodule

// File: rtl/pwm_axil_top.sv
module pwm_axil_top
   import pwm_axil_pkg::*;
#(
   parameter  int ADDR_W  = 4,
   parameter  int DATA_W  = 32,
   parameter  int CNT_W   = 8,
   parameter  bit REG_OUT = 1'b0,
   localparam int DUTY_W  = CNT_W + 1,
   localparam int STRB_W  = DATA_W / 8
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   input  logic              pwm_en,
   output logic              pwm_out,
   output logic              irq
);

   initial begin : p_cfg
      assert (CNT_W >= 2 && CNT_W <= 16) else $fatal(1, "CNT_W out of range");
      assert (DATA_W == 32 || DATA_W == 64) else $fatal(1, "DATA_W must be 32 or 64");
      assert (ADDR_W >= 3) else $fatal(1, "ADDR_W too small for two registers");
      assert (lanes_for(DUTY_W) <= STRB_W) else $fatal(1, "duty wider than bus");
   end

   logic              wr_go;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_word;
   logic [STRB_W-1:0] wr_strb;
   logic [CNT_W-1:0]  cnt_w;
   logic [DUTY_W-1:0] duty_staged_w, duty_act_w;

   pwm_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(aclk), .rstn(aresetn),
      .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
   );

   pwm_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk(aclk), .rstn(aresetn),
      .araddr(araddr), .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
      .rd_addr(rd_addr), .rd_word(rd_word)
   );

   pwm_axil_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(aclk), .rstn(aresetn),
      .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(rd_addr), .cnt(cnt_w),
      .duty(duty_staged_w), .rd_word(rd_word)
   );

   pwm_core #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_core (
      .clk(aclk), .rstn(aresetn), .en(pwm_en),
      .duty_staged(duty_staged_w),
      .cnt(cnt_w), .duty_act(duty_act_w),
      .wrap_pulse(irq), .pwm(pwm_out)
   );

endmodule

// File: rtl/pwm_axil_chk.sv
module pwm_axil_chk #(
   parameter  int CNT_W  = 8,
   localparam int DUTY_W = CNT_W + 1
) (
   input logic              clk,
   input logic              rstn,
   input logic              en,
   input logic [CNT_W-1:0]  cnt,
   input logic [DUTY_W-1:0] duty_act,
   input logic              irq,
   input logic              bvalid,
   input logic              bready,
   input logic              rvalid,
   input logic              rready
);

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstn)
      en |=> (cnt == CNT_W'($past(cnt) + 1'b1)))
      else $error("counter did not advance");

   p_irq_single_r3: assert property (@(posedge clk) disable iff (!rstn)
      irq |=> !irq)
      else $error("irq wider than one clock");

   p_irq_at_zero_r3: assert property (@(posedge clk) disable iff (!rstn)
      irq |-> (cnt == '0))
      else $error("irq away from wrap");

   p_duty_hold_r5: assert property (@(posedge clk) disable iff (!rstn)
      !$stable(duty_act) |-> (cnt == '0))
      else $error("active duty changed mid-period");

   p_freeze_r6: assert property (@(posedge clk) disable iff (!rstn)
      !en |=> ($stable(cnt) && !irq))
      else $error("counter moved while disabled");

   p_bvalid_hold_r7: assert property (@(posedge clk) disable iff (!rstn)
      (bvalid && !bready) |=> bvalid)
      else $error("write response dropped");

   p_rvalid_hold_r9: assert property (@(posedge clk) disable iff (!rstn)
      (rvalid && !rready) |=> rvalid)
      else $error("read data dropped");

endmodule

bind pwm_axil_top pwm_axil_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(aclk), .rstn(aresetn), .en(pwm_en),
   .cnt(cnt_w), .duty_act(duty_act_w), .irq(irq),
   .bvalid(bvalid), .bready(bready), .rvalid(rvalid), .rready(rready)
);

// File: tb/pwm_axil_top_tb.sv
`timescale 1ns/1ps
module pwm_axil_top_tb;

   logic        clk = 1'b0;
   logic        rstn = 1'b0;
   logic [3:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        bready = 1'b1, rready = 1'b1;
   logic        en = 1'b0;
   logic        awready, wready, bvalid, arready, rvalid, pwm_out, irq;
   logic [1:0]  bresp, rresp;
   logic [31:0] rdata;

   int total = 0, bad = 0;
   bit done = 0, mon_on = 0;

   // Bench model of the counter, active duty and pulse
   logic [7:0] m_cnt;
   logic [8:0] m_act;
   logic [8:0] m_duty = '0;
   logic       m_irq;

   always #4 clk = ~clk;

   pwm_axil_top u_dut (
      .aclk(clk), .aresetn(rstn),
      .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
      .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .araddr(araddr), .arvalid(arvalid), .arready(arready),
      .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
      .pwm_en(en), .pwm_out(pwm_out), .irq(irq)
   );

   always @(posedge clk) begin
      if (!rstn) begin
         m_cnt <= '0; m_act <= '0; m_irq <= 1'b0;
      end else begin
         m_irq <= en && (m_cnt == 8'd255);
         if (en) begin
            m_cnt <= m_cnt + 8'd1;
            if (m_cnt == 8'd255) m_act <= m_duty;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Continuous comparison of the pins against the model (R4, R3, R6)
   always @(negedge clk) begin
      if (mon_on && rstn) begin
         chk(pwm_out === ({1'b0, m_cnt} < m_act), "R4", "pwm vs model",
             pwm_out, {1'b0, m_cnt} < m_act);
         chk(irq === m_irq, "R3", "irq vs model", irq, m_irq);
      end
   end

   task automatic axi_wr(input logic [3:0] a, input logic [31:0] d,
                         input logic [3:0] s, input int order);
      bit aw_done, w_done, af, wf;
      aw_done = 0; w_done = 0;
      awaddr = a; wdata = d; wstrb = s;
      if (order != 2) awvalid = 1'b1;
      if (order != 1) wvalid = 1'b1;
      while (!(aw_done && w_done)) begin
         af = awvalid && awready;
         wf = wvalid && wready;
         @(negedge clk);
         if (af) begin awvalid = 1'b0; aw_done = 1; end
         if (wf) begin wvalid = 1'b0; w_done = 1; end
         if (order == 1 && aw_done && !w_done) wvalid = 1'b1;
         if (order == 2 && w_done && !aw_done) awvalid = 1'b1;
      end
      while (!bvalid) @(negedge clk);
      chk(bresp == 2'b00, "R7", "bresp OKAY", bresp, 0);
      if (a[3:2] == 2'd0) begin
         if (s[0]) m_duty[7:0] = d[7:0];
         if (s[1]) m_duty[8]   = d[8];
      end
      @(negedge clk);
      chk(!bvalid, "R7", "single bvalid pulse", bvalid, 0);
   endtask

   task automatic axi_rd(input logic [3:0] a, output logic [31:0] d,
                         output logic [7:0] snap);
      bit af;
      araddr = a; arvalid = 1'b1;
      af = 0;
      while (!af) begin
         af = arvalid && arready;
         if (af) snap = m_cnt;
         @(negedge clk);
      end
      arvalid = 1'b0;
      while (!rvalid) @(negedge clk);
      d = rdata;
      chk(rresp == 2'b00, "R9", "rresp OKAY", rresp, 0);
      @(negedge clk);
   endtask

   task automatic wait_cnt(input logic [7:0] v);
      while (m_cnt != v) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      logic [7:0]  snap, snap2;
      int          hi, npulse;

      repeat (5) @(negedge clk);
      chk(pwm_out === 1'b0, "R1", "pwm in reset", pwm_out, 0);
      chk(irq === 1'b0, "R1", "irq in reset", irq, 0);
      rstn = 1'b1;
      @(negedge clk);
      mon_on = 1;
      axi_rd(4'h0, d, snap);
      chk(d == 0, "R1", "duty after reset", d, 0);
      axi_rd(4'h4, d, snap);
      chk(d == 0, "R1", "count after reset", d, 0);

      // R2: counting and readback
      en = 1'b1;
      repeat (37) @(negedge clk);
      axi_rd(4'h4, d, snap);
      chk(d == {24'd0, snap}, "R2", "count readback", d, snap);
      wait_cnt(8'd254);
      repeat (3) @(negedge clk);
      chk(m_cnt == 8'd1, "R2", "model wrap sanity", m_cnt, 1);
      axi_rd(4'h4, d, snap);
      chk(d == {24'd0, snap}, "R2", "count after wrap", d, snap);

      // R4/R3: duty sweep over edge values, count high clocks per period
      foreach (sweep[i]) begin
         axi_wr(4'h0, {23'd0, sweep[i]}, 4'b0011, i % 3);
         npulse = 0;
         while (npulse < 2) begin
            @(negedge clk);
            if (irq) npulse++;
         end
         hi = 0; npulse = 0;
         for (int k = 0; k < 256; k++) begin
            if (pwm_out) hi++;
            if (irq) npulse++;
            @(negedge clk);
         end
         chk(hi == ((sweep[i] >= 256) ? 256 : sweep[i]), "R4", "high clocks per period",
             hi, (sweep[i] >= 256) ? 256 : sweep[i]);
         chk(npulse == 1, "R3", "one irq per period", npulse, 1);
      end

      // R5: mid-period duty change keeps the old value until wrap
      axi_wr(4'h0, 32'd50, 4'b0011, 0);
      wait_cnt(8'd0); wait_cnt(8'd100);
      axi_wr(4'h0, 32'd200, 4'b0011, 1);
      wait_cnt(8'd150);
      chk(pwm_out === 1'b0, "R5", "old duty still active", pwm_out, 0);
      wait_cnt(8'd0); wait_cnt(8'd150);
      chk(pwm_out === 1'b1, "R5", "new duty after wrap", pwm_out, 1);

      // R9: stored duty reads back before it is active
      wait_cnt(8'd10);
      axi_wr(4'h0, 32'd77, 4'b0011, 2);
      axi_rd(4'h0, d, snap);
      chk(d == 32'd77, "R9", "staged duty readback", d, 77);

      // R6: freeze at 255, no pulse, counter held
      wait_cnt(8'd255);
      en = 1'b0;
      npulse = 0;
      axi_rd(4'h4, d, snap);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (irq) npulse++;
      end
      axi_rd(4'h4, d, snap2);
      chk(d == 32'd255, "R6", "counter frozen at top", d, 255);
      chk(npulse == 0, "R6", "no irq while frozen", npulse, 0);
      chk(pwm_out === 1'b0, "R6", "pwm frozen", pwm_out, 0);
      en = 1'b1;

      // R8: strobe lanes and ignored upper bits
      axi_wr(4'h0, 32'hFFFF_FFFF, 4'b1111, 0);
      axi_rd(4'h0, d, snap);
      chk(d == 32'h1FF, "R8", "upper data bits ignored", d, 32'h1FF);
      axi_wr(4'h0, 32'h0000_0012, 4'b0001, 1);
      axi_rd(4'h0, d, snap);
      chk(d == 32'h112, "R8", "lane0 only keeps bit8", d, 32'h112);
      axi_wr(4'h0, 32'h0000_00AB, 4'b0010, 2);
      axi_rd(4'h0, d, snap);
      chk(d == 32'h012, "R8", "lane1 only writes bit8", d, 32'h012);
      axi_wr(4'h0, 32'h0000_01CD, 4'b1100, 0);
      axi_rd(4'h0, d, snap);
      chk(d == 32'h012, "R8", "lanes 2-3 ignored", d, 32'h012);

      // R10: other offsets
      axi_rd(4'h8, d, snap);
      chk(d == 0, "R10", "offset 0x08 reads zero", d, 0);
      axi_rd(4'hC, d, snap);
      chk(d == 0, "R10", "offset 0x0C reads zero", d, 0);
      axi_wr(4'h4, 32'h33, 4'b1111, 1);
      axi_wr(4'h8, 32'h1AA, 4'b1111, 2);
      axi_rd(4'h0, d, snap);
      chk(d == 32'h012, "R10", "duty unchanged by other writes", d, 32'h012);
      axi_rd(4'h4, d, snap);
      chk(d == {24'd0, snap}, "R10", "counter unchanged by writes", d, snap);

      // R1: reset mid-run clears everything
      mon_on = 0;
      rstn = 1'b0;
      repeat (3) @(negedge clk);
      m_duty = '0;
      chk(irq === 1'b0 && pwm_out === 1'b0, "R1", "pins in reset", {irq, pwm_out}, 0);
      rstn = 1'b1;
      en = 1'b0;
      @(negedge clk);
      mon_on = 1;
      axi_rd(4'h0, d, snap);
      chk(d == 0, "R1", "duty cleared", d, 0);
      axi_rd(4'h4, d, snap);
      chk(d == 0, "R1", "count cleared", d, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int sweep [13] = '{0, 1, 2, 3, 127, 128, 129, 254, 255, 256, 257, 300, 511};

endmodule